// File: doc/BRIEF.md
# Dynamic Bus Width Sizer

This block sits between a 16-bit processor bus and the external memory pins. A separate address decoder picks a chip-select region for each request. The sizer holds one width bit per region, so each region can be set up as either an 8-bit port or a 16-bit port.

On a 16-bit region, a request runs as a single external cycle. On an 8-bit region, a word request is split into two back-to-back byte cycles, and both bytes travel on the upper data lane. The external bit 0 of the address selects the byte in each of those cycles. Read bytes are collected into one word, which is returned together with a single acknowledge. Byte requests take one external cycle whatever the port width. A 32-bit transfer reaches this block as two separate word requests.

Every external cycle is four clocks long: one address setup clock, two clocks with the strobe asserted, and one release clock. Read data is sampled at the end of the second strobe clock.

Top module: `bus_width_sizer`

## Requirements
- R1: `width_o[n]` is the width bit of region n, where 0 means an 8-bit port and 1 means a 16-bit port. A cycle with `cfg_we_i` high loads `cfg_width_i` into all of the bits. In any other cycle the bits do not change.
- R2: When `rst_ni` is low, region 0's bit takes the level of `width_strap_i`, and every other region's bit is 1. At the same time `ack_o`, `rdata_o` and all external strobes are 0.
- R3: A word request (`size_i`=1) to an 8-bit region produces exactly two external cycles. The first drives `ext_addr_o[0]`=0 and the second drives `ext_addr_o[0]`=1. In both, only `ext_ub_o` strobes and `ext_lb_o` stays low.
- R4: A word read from an 8-bit region returns the byte from the A0=0 cycle in `rdata_o[15:8]` and the byte from the A0=1 cycle in `rdata_o[7:0]`. Each byte is taken from `ext_din_i[15:8]`. `rdata_o` changes only in the cycle in which `ack_o` is high.
- R5: A word write to an 8-bit region drives `wdata_i[15:8]` on `ext_dout_o[15:8]` in the first cycle and `wdata_i[7:0]` on `ext_dout_o[15:8]` in the second cycle.
- R6: Each external cycle keeps `ext_as_o` high for exactly two clocks. `ext_addr_o` stays stable while `ext_as_o` is high.
- R7: If a request is accepted at clock edge E, `ack_o` is high for exactly one cycle. That cycle follows edge E+4 when there is one external cycle, and edge E+8 when the request is split. A request is accepted only when the block is idle, and `req_i` must be held high until the acknowledge.
- R8: A byte request (`size_i`=0) to an 8-bit region produces one external cycle. That cycle drives `ext_addr_o[0]` = `addr_i[0]`, uses only the upper lane, and writes the data lane that `addr_i[0]` selects (0 selects `wdata_i[15:8]`, 1 selects `wdata_i[7:0]`). On a read, the byte is returned in the lane that `addr_i[0]` selects, and the other lane reads as zero.
- R9: A word request to a 16-bit region produces one external cycle. It drives `ext_addr_o[0]`=0, asserts both lane strobes, and transfers all 16 bits.
- R10: A byte request to a 16-bit region produces one external cycle. The lane is chosen by `addr_i[0]`: 0 selects the upper lane and `ext_ub_o`, 1 selects the lower lane and `ext_lb_o`. Only that lane's strobe is asserted. On a read, the other lane of `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_strap_i | input | 1 | Reset width of region 0 (1 = 16-bit) |
| cfg_we_i | input | 1 | Load the width bits |
| cfg_width_i | input | NUM_REGIONS | New width bits |
| width_o | output | NUM_REGIONS | Current width bits |
| req_i | input | 1 | Processor request, held until ack |
| we_i | input | 1 | 1 = write |
| size_i | input | 1 | 0 = byte, 1 = word |
| addr_i | input | ADDR_W | Byte address |
| region_i | input | RSEL_W | Decoded region index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with ack |
| ack_o | output | 1 | One-cycle completion pulse |
| ext_addr_o | output | ADDR_W | External address including A0 |
| ext_as_o | output | 1 | External strobe window |
| ext_ub_o | output | 1 | Upper lane strobe |
| ext_lb_o | output | 1 | Lower lane strobe |
| ext_we_o | output | 1 | External write |
| ext_oe_o | output | 1 | Data pin drive enable |
| ext_dout_o | output | 16 | External write data |
| ext_din_i | input | 16 | External read data |

## Verification
The bench counts clock cycles from the point where it raises a request. The acknowledge must appear exactly 5 cycles later for a single external cycle and 9 cycles later for a split one. `rdata_o` is sampled in that acknowledge cycle.

A pin monitor runs on the falling edge of each clock. For every strobe window it records A0, the lane strobes, the upper write byte and the strobe length. These records are compared once the acknowledge has arrived, against values that bench functions compute from a byte-addressed reference memory. Width bits are compared one cycle after a configuration write, and again after each reset.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STRB,
    PH_SAMP,
    PH_REL
  } phase_e;
endpackage

// File: rtl/bws_width_regs.sv
module bws_width_regs #(
  parameter int NUM_REGIONS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strap_i,
  input  logic                   cfg_we_i,
  input  logic [NUM_REGIONS-1:0] cfg_width_i,
  output logic [NUM_REGIONS-1:0] width_o
);
  logic [NUM_REGIONS-1:0] width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) width_q <= {{(NUM_REGIONS-1){1'b1}}, strap_i};
    else if (cfg_we_i) width_q <= cfg_width_i;
  end

  assign width_o = width_q;

  assert_cfg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(width_o));
  assert_cfg_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> width_o == $past(cfg_width_i));
endmodule

// File: rtl/bws_seq.sv
module bws_seq
  import bws_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_REGIONS = 4,
  parameter int RSEL_W      = $clog2(NUM_REGIONS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic                   size_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [RSEL_W-1:0]      region_i,
  input  logic [WORD_W-1:0]      wdata_i,
  input  logic [NUM_REGIONS-1:0] width_i,
  output phase_e                 phase_o,
  output logic                   beat_o,
  output logic                   we_o,
  output logic                   word_o,
  output logic                   narrow_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [WORD_W-1:0]      wdata_o,
  output logic                   cap_o,
  output logic                   fin_o,
  output logic                   ack_o
);
  phase_e              phase_q;
  logic                beat_q, we_q, word_q, narrow_q, ack_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                last_beat;

  // only a word on an 8-bit port needs a second beat
  assign last_beat = !(narrow_q && word_q) || beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      beat_q   <= 1'b0;
      we_q     <= 1'b0;
      word_q   <= 1'b0;
      narrow_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req_i && !ack_q) begin
          phase_q  <= PH_SETUP;
          beat_q   <= 1'b0;
          we_q     <= we_i;
          word_q   <= size_i;
          narrow_q <= !width_i[region_i];
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
        end
        PH_SETUP: phase_q <= PH_STRB;
        PH_STRB:  phase_q <= PH_SAMP;
        PH_SAMP:  phase_q <= PH_REL;
        PH_REL: begin
          if (last_beat) begin
            phase_q <= PH_IDLE;
            ack_q   <= 1'b1;
          end else begin
            phase_q <= PH_SETUP;
            beat_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign beat_o   = beat_q;
  assign we_o     = we_q;
  assign word_o   = word_q;
  assign narrow_o = narrow_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign cap_o    = phase_q == PH_SAMP;
  assign fin_o    = (phase_q == PH_REL) && last_beat;
  assign ack_o    = ack_q;

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_ack_after_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(phase_q) == PH_REL);
  assert_second_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REL && !fin_o) |=> (phase_q == PH_SETUP && beat_q && narrow_q && word_q));
endmodule

// File: rtl/bws_lane_mux.sv
module bws_lane_mux
  import bws_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              beat_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic              narrow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              a0_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              ext_as_o,
  output logic              ext_ub_o,
  output logic              ext_lb_o,
  output logic              ext_we_o,
  output logic              ext_oe_o,
  output logic [WORD_W-1:0] ext_dout_o
);
  logic active, strb_on, a0;
  logic [LANE_W-1:0] sel_byte;

  assign active  = phase_i != PH_IDLE;
  assign strb_on = (phase_i == PH_STRB) || (phase_i == PH_SAMP);
  // words: even byte on beat 0, odd byte on beat 1
  assign a0      = word_i ? beat_i : addr_i[0];
  assign sel_byte = a0 ? wdata_i[LANE_W-1:0] : wdata_i[WORD_W-1:LANE_W];

  assign a0_o       = a0;
  assign ext_addr_o = {addr_i[ADDR_W-1:1], a0};
  assign ext_as_o   = strb_on;
  assign ext_ub_o   = strb_on && (narrow_i || word_i || !a0);
  assign ext_lb_o   = strb_on && !narrow_i && (word_i || a0);
  assign ext_we_o   = active && we_i;
  assign ext_oe_o   = active && we_i;
  assign ext_dout_o = narrow_i ? {sel_byte, {LANE_W{1'b0}}} : wdata_i;

  assert_upper_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && narrow_i) |-> !ext_lb_o);
  assert_single_lane_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_as_o && !narrow_i && !word_i) |-> $countones({ext_ub_o, ext_lb_o}) == 1);
  assert_strobe_in_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_ub_o || ext_lb_o) |-> ext_as_o);
endmodule

// File: rtl/bws_gather.sv
module bws_gather
  import bws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              fin_i,
  input  logic              beat_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic              narrow_i,
  input  logic              a0_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [LANE_W-1:0] ZB = '0;

  logic [WORD_W-1:0] cap_word, asm_q, rdata_q;
  logic [LANE_W-1:0] lane_byte;

  always_comb begin
    if (narrow_i) lane_byte = din_i[WORD_W-1:LANE_W];
    else lane_byte = a0_i ? din_i[LANE_W-1:0] : din_i[WORD_W-1:LANE_W];
    if (!narrow_i && word_i) cap_word = din_i;
    else cap_word = a0_i ? {ZB, lane_byte} : {lane_byte, ZB};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (cap_i && !we_i) asm_q <= beat_i ? (asm_q | cap_word) : cap_word;
      if (fin_i && !we_i) rdata_q <= asm_q;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bus_width_sizer.sv
module bus_width_sizer
  import bws_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_REGIONS = 4,
  parameter int RSEL_W      = $clog2(NUM_REGIONS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   width_strap_i,
  input  logic                   cfg_we_i,
  input  logic [NUM_REGIONS-1:0] cfg_width_i,
  output logic [NUM_REGIONS-1:0] width_o,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic                   size_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [RSEL_W-1:0]      region_i,
  input  logic [15:0]            wdata_i,
  output logic [15:0]            rdata_o,
  output logic                   ack_o,
  output logic [ADDR_W-1:0]      ext_addr_o,
  output logic                   ext_as_o,
  output logic                   ext_ub_o,
  output logic                   ext_lb_o,
  output logic                   ext_we_o,
  output logic                   ext_oe_o,
  output logic [15:0]            ext_dout_o,
  input  logic [15:0]            ext_din_i
);
  phase_e            phase;
  logic              beat, we_q, word_q, narrow_q, cap, fin, a0;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  bws_width_regs #(.NUM_REGIONS(NUM_REGIONS)) u_width (
    .clk_i, .rst_ni, .strap_i(width_strap_i), .cfg_we_i, .cfg_width_i, .width_o
  );

  bws_seq #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .RSEL_W(RSEL_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i, .region_i, .wdata_i,
    .width_i(width_o), .phase_o(phase), .beat_o(beat), .we_o(we_q), .word_o(word_q),
    .narrow_o(narrow_q), .addr_o(addr_q), .wdata_o(wdata_q), .cap_o(cap), .fin_o(fin),
    .ack_o
  );

  bws_lane_mux #(.ADDR_W(ADDR_W)) u_lane (
    .clk_i, .rst_ni, .phase_i(phase), .beat_i(beat), .we_i(we_q), .word_i(word_q),
    .narrow_i(narrow_q), .addr_i(addr_q), .wdata_i(wdata_q), .a0_o(a0),
    .ext_addr_o, .ext_as_o, .ext_ub_o, .ext_lb_o, .ext_we_o, .ext_oe_o, .ext_dout_o
  );

  bws_gather u_gather (
    .clk_i, .rst_ni, .cap_i(cap), .fin_i(fin), .beat_i(beat), .we_i(we_q),
    .word_i(word_q), .narrow_i(narrow_q), .a0_i(a0), .din_i(ext_din_i), .rdata_o
  );

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> $stable(rdata_o));
  assert_addr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_as_o |-> $stable(ext_addr_o));
  assert_as_two_clocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_as_o) |=> ext_as_o ##1 !ext_as_o);
endmodule

// File: tb/bus_width_sizer_tb.sv
module bus_width_sizer_tb;
  localparam int AW = 24;
  localparam int NR = 4;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic cfg_we = 1'b0;
  logic [NR-1:0] cfg_width = '1, width;
  logic req = 1'b0, we = 1'b0, size = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] region = '0;
  logic [15:0] wdata = '0, rdata, dout;
  logic [15:0] din;
  logic ack, as_o, ub, lb, ewe, oe;
  logic [AW-1:0] eaddr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] bus_mem [256];
  logic [7:0] ref_mem [256];
  logic [NR-1:0] wmodel;
  logic narrow_cur = 1'b0;

  int nbeats;
  logic log_a0 [4];
  logic log_ub [4];
  logic log_lb [4];
  logic [7:0] log_up [4];
  int log_len [4];
  logic as_prev = 1'b0;

  always #10 clk = ~clk;

  bus_width_sizer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .width_strap_i(strap), .cfg_we_i(cfg_we),
    .cfg_width_i(cfg_width), .width_o(width), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .region_i(region), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .ext_addr_o(eaddr), .ext_as_o(as_o), .ext_ub_o(ub), .ext_lb_o(lb), .ext_we_o(ewe),
    .ext_oe_o(oe), .ext_dout_o(dout), .ext_din_i(din)
  );

  always_comb begin
    if (narrow_cur) din = {bus_mem[eaddr[7:0]], 8'hA5};
    else din = {bus_mem[{eaddr[7:1], 1'b0}], bus_mem[{eaddr[7:1], 1'b1}]};
  end

  // pin monitor and external memory model
  always @(negedge clk) begin
    if (as_o) begin
      if (!as_prev) begin
        if (nbeats < 4) begin
          log_a0[nbeats] = eaddr[0];
          log_ub[nbeats] = ub;
          log_lb[nbeats] = lb;
          log_up[nbeats] = dout[15:8];
          log_len[nbeats] = 1;
        end
        nbeats++;
      end else if (nbeats >= 1 && nbeats <= 4) log_len[nbeats-1]++;
      if (ewe && oe) begin
        if (narrow_cur) begin
          if (ub) bus_mem[eaddr[7:0]] = dout[15:8];
        end else begin
          if (ub) bus_mem[{eaddr[7:1], 1'b0}] = dout[15:8];
          if (lb) bus_mem[{eaddr[7:1], 1'b1}] = dout[7:0];
        end
      end
    end
    as_prev = as_o;
  end

  task automatic check(input bit ok, input string req_tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic word, input logic [7:0] a);
    if (word) return {ref_mem[{a[7:1], 1'b0}], ref_mem[{a[7:1], 1'b1}]};
    return a[0] ? {8'h00, ref_mem[a]} : {ref_mem[a], 8'h00};
  endfunction

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    repeat (2) @(negedge clk);
    // R2: reset values
    check(width == {{(NR-1){1'b1}}, s}, "R2", width, {{(NR-1){1'b1}}, s});
    check(!ack && rdata == 16'h0 && !ub && !lb && !as_o, "R2", {ack, rdata}, 0);
    rst_n = 1'b1;
    wmodel = {{(NR-1){1'b1}}, s};
    @(negedge clk);
  endtask

  task automatic set_width(input logic [NR-1:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_width = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_width = ~w;
    check(width == w, "R1 load", width, w);
    @(negedge clk);
    check(width == w, "R1 hold", width, w);
    wmodel = w;
  endtask

  task automatic xfer(input logic [1:0] rg, input logic w, input logic wd,
                      input logic [7:0] a, input logic [15:0] d);
    int cnt;
    logic nar, split;
    logic [7:0] aa;
    logic [15:0] got;
    aa = wd ? {a[7:1], 1'b0} : a;
    nar = !wmodel[rg];
    split = nar && wd;
    narrow_cur = nar;
    nbeats = 0;
    req = 1'b1; we = w; size = wd; region = rg; addr = {16'h0, aa}; wdata = d;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!ack && cnt < 40);
    got = rdata;
    req = 1'b0;
    // R7: ack timing
    check(cnt == (split ? 9 : 5), "R7 latency", cnt, split ? 9 : 5);
    @(negedge clk);
    check(!ack, "R7 pulse", ack, 0);
    check(nbeats == (split ? 2 : 1), split ? "R3 beats" : "R8/R9 beats", nbeats, split ? 2 : 1);
    for (int i = 0; i < nbeats && i < 4; i++)
      check(log_len[i] == 2, "R6 strobe length", log_len[i], 2);
    if (split && nbeats == 2) begin
      check(!log_a0[0] && log_a0[1], "R3 a0 order", {log_a0[0], log_a0[1]}, 2'b01);
      check(log_ub[0] && log_ub[1] && !log_lb[0] && !log_lb[1], "R3 lanes",
            {log_ub[0], log_lb[0], log_ub[1], log_lb[1]}, 4'b1010);
      if (w) check({log_up[0], log_up[1]} == d, "R5 write bytes", {log_up[0], log_up[1]}, d);
    end else if (nbeats >= 1) begin
      if (nar) begin
        check(log_a0[0] == aa[0] && log_ub[0] && !log_lb[0], "R8 byte cycle",
              {log_a0[0], log_ub[0], log_lb[0]}, {aa[0], 2'b10});
        if (w) check(log_up[0] == (aa[0] ? d[7:0] : d[15:8]), "R8 write lane", log_up[0],
                     aa[0] ? d[7:0] : d[15:8]);
      end else if (wd) begin
        check(!log_a0[0] && log_ub[0] && log_lb[0], "R9 word cycle",
              {log_a0[0], log_ub[0], log_lb[0]}, 3'b011);
      end else begin
        check(log_a0[0] == aa[0] && log_ub[0] == !aa[0] && log_lb[0] == aa[0], "R10 lane",
              {log_a0[0], log_ub[0], log_lb[0]}, {aa[0], !aa[0], aa[0]});
      end
    end
    if (w) begin
      if (wd) begin
        ref_mem[aa] = d[15:8];
        ref_mem[aa | 8'h01] = d[7:0];
      end else ref_mem[aa] = aa[0] ? d[7:0] : d[15:8];
    end else begin
      check(got == exp_read(wd, aa),
            split ? "R4 gather" : (nar ? "R8 read" : (wd ? "R9 read" : "R10 read")),
            got, exp_read(wd, aa));
    end
    // R4: rdata stays put after the acknowledge cycle
    check(rdata == got, "R4 hold", rdata, got);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bus_mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    void'($urandom(32'd4242));
    do_reset(1'b0);
    // region 0 is 8-bit from strap, others 16-bit
    xfer(2'd0, 1'b1, 1'b1, 8'h10, 16'hBEEF);
    xfer(2'd0, 1'b0, 1'b1, 8'h10, 16'h0);
    xfer(2'd0, 1'b0, 1'b0, 8'h11, 16'h0);
    xfer(2'd0, 1'b1, 1'b0, 8'h13, 16'h00C4);
    xfer(2'd0, 1'b0, 1'b1, 8'h12, 16'h0);
    xfer(2'd1, 1'b1, 1'b1, 8'h20, 16'h1234);
    xfer(2'd1, 1'b0, 1'b0, 8'h21, 16'h0);
    xfer(2'd1, 1'b0, 1'b0, 8'h20, 16'h0);
    xfer(2'd2, 1'b1, 1'b0, 8'h31, 16'h00AB);
    xfer(2'd2, 1'b1, 1'b0, 8'h30, 16'hCD00);
    xfer(2'd3, 1'b0, 1'b1, 8'h30, 16'h0);
    do_reset(1'b1);
    xfer(2'd0, 1'b0, 1'b1, 8'h10, 16'h0);
    set_width(4'b0101);
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 49) set_width(4'($urandom_range(0, 15)));
      xfer(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)), 16'($urandom_range(0, 65535)));
    end
    for (int i = 0; i < 256; i++)
      if (bus_mem[i] != ref_mem[i]) check(1'b0, "R5 memory image", bus_mem[i], ref_mem[i]);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule